// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block decides where each operand of a five-stage in-order integer pipeline comes from, and when the front end must wait. The five stages are fetch, decode with register read, execute, memory and writeback. It compares the source register numbers of the instruction in execute with the destination numbers held in the two later pipeline registers. From that it drives the select inputs of the two ALU operand multiplexers. The second operand select also steers the store-data path while the store is in execute. A further select feeds a load result arriving in writeback into the write-data input of a store that has just reached the memory stage.

A load followed at once by an instruction whose ALU needs the loaded value cannot be covered by bypassing. In that case the block raises a hold for the program counter and the fetch/decode register, and a bubble request that clears the control fields entering execute. It is purely combinational and works on abstract pipeline-register fields. The register file, ALU and memories sit outside it. Only read-after-write dependences are resolved, because every instruction reads registers in decode and writes them in writeback.

Top module: `pipe_hazard_unit`

## Requirements
- R1: With every input low, both ALU selects read 2'b00 (register file), the store select is 0, and neither hold nor bubble is raised.
- R2: When the execute-stage source equals the memory-stage destination, that stage writes a register, and it is not a load, the operand select is 2'b10. This applies to either operand independently.
- R3: When the execute-stage source equals the writeback-stage destination and that stage writes a register, the operand select is 2'b01, unless R2 applies.
- R4: When both later stages match the same source, the memory-stage value (2'b10) wins.
- R5: A stage whose register-write enable is low is never used as a bypass source and never causes a stall.
- R6: A destination of register 0 is never bypassed and never causes a stall. This holds when parameter ZERO_REG_FIXED is 1, which is the default.
- R7: When the instruction in execute is a register-writing load whose destination matches a source of the decode instruction used as an ALU input, hold_front and bubble_ex are both 1. Otherwise both are 0.
- R8: A store in decode whose data register (second source) is the only match against a load in execute causes no stall. A match on its base register (first source) does stall.
- R9: A load in the memory stage is never selected as an execute bypass source. A matching writeback-stage value is then used (2'b01), and with no such value the register file (2'b00) is used.
- R10: fwd_store is 1 exactly when the memory-stage instruction is a store whose data register equals a nonzero register-writing writeback destination.
- R11: A decode source whose use flag is low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_ADDR_W | First source of decode instruction |
| id_rs2 | input | REG_ADDR_W | Second source of decode instruction |
| id_rs1_used | input | 1 | First source feeds the ALU |
| id_rs2_used | input | 1 | Second source is read |
| id_is_store | input | 1 | Decode instruction is a store (second source is its data) |
| ex_rs1 | input | REG_ADDR_W | First source of execute instruction |
| ex_rs2 | input | REG_ADDR_W | Second source of execute instruction |
| idex_rd | input | REG_ADDR_W | Destination of execute instruction |
| idex_reg_wr | input | 1 | Execute instruction writes a register |
| idex_is_load | input | 1 | Execute instruction is a load |
| exmem_rd | input | REG_ADDR_W | Destination held in memory stage |
| exmem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| exmem_is_load | input | 1 | Memory-stage instruction is a load |
| exmem_is_store | input | 1 | Memory-stage instruction is a store |
| exmem_rs2 | input | REG_ADDR_W | Data register of memory-stage store |
| memwb_rd | input | REG_ADDR_W | Destination held in writeback stage |
| memwb_reg_wr | input | 1 | Writeback-stage instruction writes a register |
| fwd_a | output | 2 | First ALU operand select: 00 file, 01 writeback, 10 memory stage |
| fwd_b | output | 2 | Second ALU operand and store-data select, same coding |
| fwd_store | output | 1 | Memory write data taken from writeback result |
| hold_front | output | 1 | Freeze program counter and fetch/decode register |
| bubble_ex | output | 1 | Clear control fields entering execute |

## Verification
The bench makes both later stages claim the same source. A unit that ranks them wrongly would feed the older writeback value into the ALU. It drives register 0 as a destination with its write enable high, where a careless comparator would bypass a nonzero stale value or stall for nothing. It places a load in the memory stage against a matching execute source. Selecting the memory stage there would hand an address to the ALU, or to the store data in place of loaded data. It also separates a store's data register from its base register against a load one stage ahead. A unit that treats them alike either stalls needlessly or lets the base address use an unloaded value.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
   typedef enum logic [1:0] {
      SEL_FILE  = 2'b00,
      SEL_WBACK = 2'b01,
      SEL_MSTG  = 2'b10
   } opnd_sel_e;
endpackage

// File: rtl/hazard_match.sv
module hazard_match #(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] src,
   input  logic [REG_ADDR_W-1:0] dst,
   input  logic                  wr_en,
   output logic                  hit
);
   generate
      if (ZERO_REG_FIXED) begin : g_zero_fixed
         assign hit = wr_en && (dst == src) && (|dst);
      end else begin : g_zero_plain
         assign hit = wr_en && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
   import hazard_pkg::*;
#(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] src,
   input  logic [REG_ADDR_W-1:0] exmem_rd,
   input  logic                  exmem_reg_wr,
   input  logic                  exmem_is_load,
   input  logic [REG_ADDR_W-1:0] memwb_rd,
   input  logic                  memwb_reg_wr,
   output logic [1:0]            sel
);
   logic hit_m, hit_w;
   opnd_sel_e sel_e;

   hazard_match #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_m (
      .src(src), .dst(exmem_rd), .wr_en(exmem_reg_wr && !exmem_is_load), .hit(hit_m));
   hazard_match #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_w (
      .src(src), .dst(memwb_rd), .wr_en(memwb_reg_wr), .hit(hit_w));

   always_comb begin
      if (hit_m)      sel_e = SEL_MSTG;
      else if (hit_w) sel_e = SEL_WBACK;
      else            sel_e = SEL_FILE;
   end
   assign sel = sel_e;

   always_comb begin
      AST_SEL_LEGAL: assert (sel != 2'b11);                                        // R2
      AST_MSTG_SOURCE: assert (sel != 2'b10 ||
         (exmem_reg_wr && !exmem_is_load && exmem_rd == src));                    // R9
      AST_WBACK_SOURCE: assert (sel != 2'b01 || (memwb_reg_wr && memwb_rd == src)); // R3
      AST_YOUNGER_WINS: assert (!(sel == 2'b01 && exmem_reg_wr && !exmem_is_load &&
         exmem_rd == src && (|src || !ZERO_REG_FIXED)));                          // R4
   end
endmodule

// File: rtl/load_use_check.sv
module load_use_check #(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] id_rs1,
   input  logic [REG_ADDR_W-1:0] id_rs2,
   input  logic                  id_rs1_used,
   input  logic                  id_rs2_used,
   input  logic                  id_is_store,
   input  logic [REG_ADDR_W-1:0] idex_rd,
   input  logic                  idex_reg_wr,
   input  logic                  idex_is_load,
   output logic                  need_stall
);
   logic ld_wr, hit1, hit2;
   assign ld_wr = idex_reg_wr && idex_is_load;

   hazard_match #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_s1 (
      .src(id_rs1), .dst(idex_rd), .wr_en(ld_wr && id_rs1_used), .hit(hit1));
   // a store's data operand is caught later by the memory-stage bypass
   hazard_match #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_s2 (
      .src(id_rs2), .dst(idex_rd), .wr_en(ld_wr && id_rs2_used && !id_is_store), .hit(hit2));

   assign need_stall = hit1 || hit2;

   always_comb begin
      AST_STALL_NEEDS_LOAD: assert (!need_stall || (idex_is_load && idex_reg_wr));   // R7
      AST_STALL_NEEDS_USE: assert (!need_stall || id_rs1_used || id_rs2_used);       // R11
   end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
   import hazard_pkg::*;
#(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] id_rs1,
   input  logic [REG_ADDR_W-1:0] id_rs2,
   input  logic                  id_rs1_used,
   input  logic                  id_rs2_used,
   input  logic                  id_is_store,
   input  logic [REG_ADDR_W-1:0] ex_rs1,
   input  logic [REG_ADDR_W-1:0] ex_rs2,
   input  logic [REG_ADDR_W-1:0] idex_rd,
   input  logic                  idex_reg_wr,
   input  logic                  idex_is_load,
   input  logic [REG_ADDR_W-1:0] exmem_rd,
   input  logic                  exmem_reg_wr,
   input  logic                  exmem_is_load,
   input  logic                  exmem_is_store,
   input  logic [REG_ADDR_W-1:0] exmem_rs2,
   input  logic [REG_ADDR_W-1:0] memwb_rd,
   input  logic                  memwb_reg_wr,
   output logic [1:0]            fwd_a,
   output logic [1:0]            fwd_b,
   output logic                  fwd_store,
   output logic                  hold_front,
   output logic                  bubble_ex
);
   localparam int NUM_ALU_SRC = 2;

   generate
      if (REG_ADDR_W < 1 || REG_ADDR_W > 8) begin : g_bad_width
         $error("REG_ADDR_W out of range");
      end
   endgenerate

   logic [REG_ADDR_W-1:0] src_arr [NUM_ALU_SRC];
   logic [1:0]            sel_arr [NUM_ALU_SRC];
   logic                  stall_req;

   assign src_arr[0] = ex_rs1;
   assign src_arr[1] = ex_rs2;

   generate
      for (genvar g = 0; g < NUM_ALU_SRC; g++) begin : g_opnd
         operand_bypass #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_byp (
            .src(src_arr[g]), .exmem_rd(exmem_rd), .exmem_reg_wr(exmem_reg_wr),
            .exmem_is_load(exmem_is_load), .memwb_rd(memwb_rd),
            .memwb_reg_wr(memwb_reg_wr), .sel(sel_arr[g]));
      end
   endgenerate

   assign fwd_a = sel_arr[0];
   assign fwd_b = sel_arr[1];

   hazard_match #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_store_byp (
      .src(exmem_rs2), .dst(memwb_rd), .wr_en(memwb_reg_wr && exmem_is_store),
      .hit(fwd_store));

   load_use_check #(.REG_ADDR_W(REG_ADDR_W), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_lu (
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs1_used(id_rs1_used),
      .id_rs2_used(id_rs2_used), .id_is_store(id_is_store), .idex_rd(idex_rd),
      .idex_reg_wr(idex_reg_wr), .idex_is_load(idex_is_load), .need_stall(stall_req));

   assign hold_front = stall_req;
   assign bubble_ex  = stall_req;

   always_comb begin
      AST_NO_ZERO_BYPASS: assert (!ZERO_REG_FIXED ||
         ((fwd_a == 2'b00 || ex_rs1 != '0) && (fwd_b == 2'b00 || ex_rs2 != '0)));  // R6
      AST_STORE_BYP_SRC: assert (!fwd_store || (exmem_is_store && memwb_reg_wr));  // R10
      AST_IDLE_QUIET: assert (exmem_reg_wr || memwb_reg_wr ||
         (fwd_a == 2'b00 && fwd_b == 2'b00));                                       // R5
   end
endmodule

// File: tb/pipe_hazard_unit_bench.sv
module pipe_hazard_unit_bench;
   localparam int AW = 5;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
   logic [AW-1:0] idex_rd = '0, exmem_rd = '0, exmem_rs2 = '0, memwb_rd = '0;
   logic id_rs1_used = 0, id_rs2_used = 0, id_is_store = 0;
   logic idex_reg_wr = 0, idex_is_load = 0;
   logic exmem_reg_wr = 0, exmem_is_load = 0, exmem_is_store = 0, memwb_reg_wr = 0;
   logic [1:0] fwd_a, fwd_b;
   logic fwd_store, hold_front, bubble_ex;

   int total = 0, bad = 0;
   bit done = 0;

   pipe_hazard_unit #(.REG_ADDR_W(AW)) u_pipe_hazard_unit (.*);

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk);
      {id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, exmem_rs2, memwb_rd} = '0;
      {id_rs1_used, id_rs2_used, id_is_store, idex_reg_wr, idex_is_load} = '0;
      {exmem_reg_wr, exmem_is_load, exmem_is_store, memwb_reg_wr} = '0;
   endtask

   task automatic settle(); #1; endtask

   task automatic chk_stall(string req, int exp);
      chk({req, " hold"}, hold_front, exp);
      chk({req, " bubble"}, bubble_ex, exp);
   endtask

   task automatic t_idle();
      clear_all(); settle();
      chk("R1 fwd_a", fwd_a, 0); chk("R1 fwd_b", fwd_b, 0);
      chk("R1 store", fwd_store, 0); chk_stall("R1", 0);
   endtask

   task automatic t_mstg();
      clear_all(); ex_rs1 = 3; ex_rs2 = 4; exmem_rd = 3; exmem_reg_wr = 1; settle();
      chk("R2 a", fwd_a, 2); chk("R2 b untouched", fwd_b, 0);
      exmem_rd = 4; settle();
      chk("R2 b", fwd_b, 2); chk("R2 a untouched", fwd_a, 0);
   endtask

   task automatic t_wback();
      clear_all(); ex_rs2 = 5; memwb_rd = 5; memwb_reg_wr = 1; settle();
      chk("R3 b", fwd_b, 1); chk("R3 a", fwd_a, 0);
   endtask

   task automatic t_priority();
      clear_all(); ex_rs1 = 7; ex_rs2 = 7; exmem_rd = 7; memwb_rd = 7;
      exmem_reg_wr = 1; memwb_reg_wr = 1; settle();
      chk("R4 a", fwd_a, 2); chk("R4 b", fwd_b, 2);
   endtask

   task automatic t_wr_off();
      clear_all(); ex_rs1 = 3; ex_rs2 = 6; exmem_rd = 3; memwb_rd = 6; settle();
      chk("R5 a", fwd_a, 0); chk("R5 b", fwd_b, 0);
      idex_is_load = 1; idex_rd = 9; id_rs1 = 9; id_rs1_used = 1; settle();
      chk_stall("R5", 0);
   endtask

   task automatic t_zero();
      clear_all(); exmem_reg_wr = 1; memwb_reg_wr = 1; settle();
      chk("R6 a", fwd_a, 0); chk("R6 b", fwd_b, 0);
      idex_is_load = 1; idex_reg_wr = 1; id_rs1_used = 1; id_rs2_used = 1; settle();
      chk_stall("R6", 0);
      exmem_is_store = 1; settle();
      chk("R6 store", fwd_store, 0);
   endtask

   task automatic t_load_use();
      clear_all(); idex_is_load = 1; idex_reg_wr = 1; idex_rd = 8;
      id_rs1 = 8; id_rs1_used = 1; id_rs2 = 2; id_rs2_used = 1; settle();
      chk_stall("R7 rs1", 1);
      id_rs1 = 2; id_rs2 = 8; settle();
      chk_stall("R7 rs2", 1);
      idex_is_load = 0; settle();
      chk_stall("R7 alu producer", 0);
   endtask

   task automatic t_store_id();
      clear_all(); idex_is_load = 1; idex_reg_wr = 1; idex_rd = 10;
      id_is_store = 1; id_rs1 = 1; id_rs1_used = 1; id_rs2 = 10; id_rs2_used = 1; settle();
      chk_stall("R8 data reg", 0);
      id_rs1 = 10; id_rs2 = 3; settle();
      chk_stall("R8 base reg", 1);
   endtask

   task automatic t_mstg_load();
      clear_all(); ex_rs2 = 9; exmem_rd = 9; exmem_reg_wr = 1; exmem_is_load = 1; settle();
      chk("R9 no wb", fwd_b, 0);
      memwb_rd = 9; memwb_reg_wr = 1; settle();
      chk("R9 falls to wb", fwd_b, 1);
   endtask

   task automatic t_store_fwd();
      clear_all(); exmem_is_store = 1; exmem_rs2 = 6; memwb_rd = 6; memwb_reg_wr = 1; settle();
      chk("R10 hit", fwd_store, 1);
      exmem_is_store = 0; settle();
      chk("R10 not store", fwd_store, 0);
      exmem_is_store = 1; memwb_rd = 7; settle();
      chk("R10 mismatch", fwd_store, 0);
      memwb_rd = 6; memwb_reg_wr = 0; settle();
      chk("R10 no wr", fwd_store, 0);
   endtask

   task automatic t_unused();
      clear_all(); idex_is_load = 1; idex_reg_wr = 1; idex_rd = 12;
      id_rs1 = 12; id_rs2 = 12; settle();
      chk_stall("R11 none used", 0);
      id_rs2_used = 1; settle();
      chk_stall("R11 rs2 used", 1);
   endtask

   initial begin
      t_idle(); t_mstg(); t_wback(); t_priority(); t_wr_off(); t_zero();
      t_load_use(); t_store_id(); t_mstg_load(); t_store_fwd(); t_unused();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule